// File: doc/BRIEF.md
# Framebuffer Fetch DMA

This block reads a picture out of memory and feeds it, one word per beat, into the pixel FIFO of a raster display pipeline. Two framebuffer regions are configured, each by a first and a last word address. The engine walks the current region in bursts. When the burst that holds the region's last address has been delivered, it switches to the other region and signals the end of the frame. Pointing both regions at the same memory repeats one picture. Pointing them at different memory gives double buffering, so software can draw the hidden buffer while the shown one is fetched.

A burst is issued only when two conditions hold: the downstream FIFO has room for the whole burst, and its fill level has dropped below a coded threshold. A programmable idle gap separates the end of one burst (or the enable) from the next request. The memory side is a simple request/grant port that returns one data beat for each `mem_rvalid`. Configuration is assumed static while the engine is enabled.

Top module: `fb_fetch_engine`

## Requirements
- R1: While and directly after reset with `enable` low, `mem_req`, `fifo_wr` and `frame_done` are 0.
- R2: The burst size code maps 0,1,2,3,4 to 1,2,4,8,16 words. Codes 5, 6 and 7 also give 16 words.
- R3: Each request asks for min(burst size, last address − current address + 1) words. Successive requests and beats cover consecutive word addresses, and the region's last address is fetched inclusively.
- R4: After the burst that contains a region's last address, the next request starts at the other region's first address. Regions alternate 0,1,0,1 starting with region 0.
- R5: `frame_done` is high for exactly one cycle, in the cycle after the edge that takes a region's final beat. `frame_buf` gives the finished region (0 or 1).
- R6: With both regions programmed identically, the same addresses are fetched every frame, and one `frame_done` is raised per pass.
- R7: No request is raised while `fifo_level` ≥ (thresh_code+1)·FIFO_DEPTH/8.
- R8: No request is raised while FIFO_DEPTH − `fifo_level` is smaller than the length the request would carry.
- R9: With the FIFO gate open, `mem_req` first rises req_delay+3 rising edges after enabling, counting the edge that samples `enable` high. After a burst, it likewise rises req_delay+2 edges after the edge taking the final beat.
- R10: A raised request keeps `mem_req`, `mem_addr` and `mem_len` unchanged until it is taken on an edge with `mem_gnt` high.
- R11: Every `mem_rvalid` beat of an accepted burst produces `fifo_wr` with `fifo_wdata` = `mem_rdata` in the same cycle. `mem_rvalid` outside a burst produces no write.
- R12: Dropping `enable` lets a granted burst deliver all its words, after which no request is raised. The next enable begins at region 0's first address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run the engine |
| base0_addr | input | AW | First word address of region 0 |
| ceil0_addr | input | AW | Last word address of region 0 |
| base1_addr | input | AW | First word address of region 1 |
| ceil1_addr | input | AW | Last word address of region 1 |
| burst_code | input | 3 | Burst size code (R2) |
| thresh_code | input | 3 | FIFO threshold code (R7) |
| req_delay | input | DLYW | Idle cycles before a request |
| fifo_level | input | log2(FIFO_DEPTH)+1 | Words held in the pixel FIFO |
| mem_req | output | 1 | Burst read request |
| mem_addr | output | AW | First word address of the burst |
| mem_len | output | 5 | Words in the burst |
| mem_gnt | input | 1 | Request accepted on this edge |
| mem_rvalid | input | 1 | Read data beat valid |
| mem_rdata | input | DW | Read data beat |
| fifo_wr | output | 1 | Write strobe toward the pixel FIFO |
| fifo_wdata | output | DW | Word written to the pixel FIFO |
| frame_done | output | 1 | One-cycle end-of-region pulse |
| frame_buf | output | 1 | Region that just finished |

## Verification
`fifo_wr` and `fifo_wdata` are combinational from a beat, so the bench checks them in the same cycle it drives `mem_rvalid`, one time unit after the falling edge. `frame_done` is registered and is expected exactly one edge later, in the cycle after the checked final write. Request address and length are compared at the falling edge where the grant is driven, before the edge that takes them. The request latency of R9 is measured by counting rising edges from the one that samples `enable` and comparing with req_delay+3. Gate and disable cases are sampled over fixed windows of 40 cycles.

// File: rtl/fbf_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers of the framebuffer fetch engine.
// Assumes burst lengths never exceed 16 words.
package fbf_pkg;

    localparam int LENW = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DELAY,
        ST_ARM,
        ST_REQ,
        ST_DATA
    } fbf_state_e;

    // Words per burst for a 3-bit size code; codes above 4 saturate at 16.
    function automatic logic [LENW-1:0] burst_words(input logic [2:0] code);
        logic [LENW-1:0] w;
        case (code)
            3'd0:    w = LENW'(1);
            3'd1:    w = LENW'(2);
            3'd2:    w = LENW'(4);
            3'd3:    w = LENW'(8);
            default: w = LENW'(16);
        endcase
        return w;
    endfunction

endpackage

// File: rtl/fbf_cfg_decode.sv
`timescale 1ns/1ps
// Turns the coded burst size and FIFO threshold into word counts.
// Assumes FIFO_DEPTH is a power of two; the threshold is (code+1)/8 of depth.
module fbf_cfg_decode #(
    parameter int FIFO_DEPTH = 64,
    parameter int LVLW       = 7
) (
    input  logic [2:0]                 burst_code,
    input  logic [2:0]                 thresh_code,
    output logic [fbf_pkg::LENW-1:0]   blen,
    output logic [LVLW-1:0]            thresh_lvl
);
    import fbf_pkg::*;

    // Burst length lookup.
    always_comb begin : burst_lookup
        blen = burst_words(burst_code);
    end

    generate
        if (FIFO_DEPTH >= 8) begin : g_step
            localparam int STEP = FIFO_DEPTH / 8;
            // Threshold in whole eighths of the FIFO.
            always_comb begin : thresh_calc
                thresh_lvl = LVLW'((int'(thresh_code) + 1) * STEP);
            end
        end else begin : g_small
            // Shallow FIFO: scale, never below one word.
            always_comb begin : thresh_calc
                int t;
                t = ((int'(thresh_code) + 1) * FIFO_DEPTH) / 8;
                thresh_lvl = (t < 1) ? LVLW'(1) : LVLW'(t);
            end
        end
    endgenerate

endmodule

// File: rtl/fbf_addr_seq.sv
`timescale 1ns/1ps
// Tracks the current fetch address and region, trims bursts at the region's
// last address, swaps regions and raises the end-of-frame pulse.
// Assumes base <= ceiling for both regions and static configuration.
module fbf_addr_seq #(
    parameter int AW = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [AW-1:0]              base0_addr,
    input  logic [AW-1:0]              ceil0_addr,
    input  logic [AW-1:0]              base1_addr,
    input  logic [AW-1:0]              ceil1_addr,
    input  logic [fbf_pkg::LENW-1:0]   blen,
    input  logic                       restart,
    input  logic                       advance,
    output logic [AW-1:0]              cur_addr,
    output logic [fbf_pkg::LENW-1:0]   eff_len,
    output logic                       eof,
    output logic                       eof_buf
);
    import fbf_pkg::*;

    logic            region;
    logic [AW-1:0]   ceil_cur;
    logic [AW:0]     remaining;
    logic            last_burst;

    // Words left in the region, last address inclusive.
    always_comb begin : span_calc
        ceil_cur   = region ? ceil1_addr : ceil0_addr;
        remaining  = {1'b0, ceil_cur} - {1'b0, cur_addr} + (AW+1)'(1);
        last_burst = remaining <= (AW+1)'(blen);
        eff_len    = last_burst ? LENW'(remaining) : blen;
    end

    // Address and region register with region swap on the final burst.
    always_ff @(posedge clk) begin : addr_update
        if (!rst_n) begin
            cur_addr <= '0;
            region   <= 1'b0;
            eof      <= 1'b0;
            eof_buf  <= 1'b0;
        end else begin
            eof <= 1'b0;
            if (restart) begin
                cur_addr <= base0_addr;
                region   <= 1'b0;
            end else if (advance) begin
                if (last_burst) begin
                    region   <= ~region;
                    cur_addr <= region ? base0_addr : base1_addr;
                    eof      <= 1'b1;
                    eof_buf  <= region;
                end else begin
                    cur_addr <= cur_addr + AW'(eff_len);
                end
            end
        end
    end

    // R5
    eof_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eof |=> !eof);

    // R4
    region_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eof |-> (cur_addr == (eof_buf ? base0_addr : base1_addr)));

endmodule

// File: rtl/fbf_gate.sv
`timescale 1ns/1ps
// Decides whether the pixel FIFO can take the next burst: level below the
// threshold and enough free words for the whole burst.
// Assumes fifo_level never exceeds FIFO_DEPTH.
module fbf_gate #(
    parameter int FIFO_DEPTH = 64,
    parameter int LVLW       = 7
) (
    input  logic [LVLW-1:0]            fifo_level,
    input  logic [LVLW-1:0]            thresh_lvl,
    input  logic [fbf_pkg::LENW-1:0]   eff_len,
    output logic                       gate_ok
);
    logic [LVLW:0] free_words;

    // Room and threshold test.
    always_comb begin : room_test
        free_words = (LVLW+1)'(FIFO_DEPTH) - {1'b0, fifo_level};
        gate_ok    = (fifo_level < thresh_lvl) &&
                     (free_words >= (LVLW+1)'(eff_len));
    end

endmodule

// File: rtl/fbf_fsm.sv
`timescale 1ns/1ps
// Burst sequencer: idle gap, FIFO gate wait, request hold until grant and
// beat counting. A granted burst always runs to its last beat.
// Assumes one burst in flight at a time and in-order beats.
module fbf_fsm #(
    parameter int DLYW = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enable,
    input  logic [DLYW-1:0]            req_delay,
    input  logic                       gate_ok,
    input  logic [fbf_pkg::LENW-1:0]   eff_len,
    input  logic                       mem_gnt,
    input  logic                       mem_rvalid,
    output logic                       mem_req,
    output logic                       fifo_wr,
    output logic                       restart,
    output logic                       advance
);
    import fbf_pkg::*;

    fbf_state_e            state;
    logic [DLYW-1:0]       dly_cnt;
    logic [LENW-1:0]       beats_left;

    // State, delay counter and beat counter.
    always_ff @(posedge clk) begin : state_update
        if (!rst_n) begin
            state      <= ST_IDLE;
            dly_cnt    <= '0;
            beats_left <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (enable) begin
                        state   <= ST_DELAY;
                        dly_cnt <= req_delay;
                    end
                end
                ST_DELAY: begin
                    if (!enable)                 state   <= ST_IDLE;
                    else if (dly_cnt == '0)      state   <= ST_ARM;
                    else                         dly_cnt <= dly_cnt - DLYW'(1);
                end
                ST_ARM: begin
                    if (!enable)      state <= ST_IDLE;
                    else if (gate_ok) state <= ST_REQ;
                end
                ST_REQ: begin
                    if (mem_gnt) begin
                        state      <= ST_DATA;
                        beats_left <= eff_len;
                    end
                end
                ST_DATA: begin
                    if (mem_rvalid) begin
                        if (beats_left == LENW'(1)) begin
                            if (enable) begin
                                state   <= ST_DELAY;
                                dly_cnt <= req_delay;
                            end else begin
                                state   <= ST_IDLE;
                            end
                        end else begin
                            beats_left <= beats_left - LENW'(1);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output decode from the state.
    always_comb begin : out_decode
        mem_req = (state == ST_REQ);
        fifo_wr = (state == ST_DATA) && mem_rvalid;
        advance = fifo_wr && (beats_left == LENW'(1));
        restart = (state == ST_IDLE);
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> mem_req);

    // R7 R8
    gate_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARM && !gate_ok) |=> !mem_req);

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !enable) |=> !mem_req);

endmodule

// File: rtl/fb_fetch_engine.sv
`timescale 1ns/1ps
// Framebuffer fetch engine: streams two ping-pong regions into a pixel FIFO
// by burst reads, gated by FIFO room and threshold, with end-of-frame pulses.
// Assumes configuration is held stable while enable is high.
module fb_fetch_engine #(
    parameter int AW         = 16,
    parameter int DW         = 32,
    parameter int FIFO_DEPTH = 64,
    parameter int DLYW       = 8,
    localparam int LVLW      = $clog2(FIFO_DEPTH) + 1,
    localparam int LENW      = fbf_pkg::LENW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [AW-1:0]     base0_addr,
    input  logic [AW-1:0]     ceil0_addr,
    input  logic [AW-1:0]     base1_addr,
    input  logic [AW-1:0]     ceil1_addr,
    input  logic [2:0]        burst_code,
    input  logic [2:0]        thresh_code,
    input  logic [DLYW-1:0]   req_delay,
    input  logic [LVLW-1:0]   fifo_level,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    output logic [LENW-1:0]   mem_len,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [DW-1:0]     mem_rdata,
    output logic              fifo_wr,
    output logic [DW-1:0]     fifo_wdata,
    output logic              frame_done,
    output logic              frame_buf
);
    logic [LENW-1:0]  blen;
    logic [LVLW-1:0]  thresh_lvl;
    logic [LENW-1:0]  eff_len;
    logic             gate_ok;
    logic             restart;
    logic             advance;

    fbf_cfg_decode #(.FIFO_DEPTH(FIFO_DEPTH), .LVLW(LVLW)) u_dec (
        .burst_code  (burst_code),
        .thresh_code (thresh_code),
        .blen        (blen),
        .thresh_lvl  (thresh_lvl)
    );

    fbf_addr_seq #(.AW(AW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .base0_addr (base0_addr),
        .ceil0_addr (ceil0_addr),
        .base1_addr (base1_addr),
        .ceil1_addr (ceil1_addr),
        .blen       (blen),
        .restart    (restart),
        .advance    (advance),
        .cur_addr   (mem_addr),
        .eff_len    (eff_len),
        .eof        (frame_done),
        .eof_buf    (frame_buf)
    );

    fbf_gate #(.FIFO_DEPTH(FIFO_DEPTH), .LVLW(LVLW)) u_gate (
        .fifo_level (fifo_level),
        .thresh_lvl (thresh_lvl),
        .eff_len    (eff_len),
        .gate_ok    (gate_ok)
    );

    fbf_fsm #(.DLYW(DLYW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .req_delay  (req_delay),
        .gate_ok    (gate_ok),
        .eff_len    (eff_len),
        .mem_gnt    (mem_gnt),
        .mem_rvalid (mem_rvalid),
        .mem_req    (mem_req),
        .fifo_wr    (fifo_wr),
        .restart    (restart),
        .advance    (advance)
    );

    // Request length and data pass-through to the FIFO.
    always_comb begin : port_map
        mem_len    = eff_len;
        fifo_wdata = mem_rdata;
    end

    // R2 R3
    len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_len != '0) && (mem_len <= blen));

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> $stable(mem_addr) && $stable(mem_len));

endmodule

// File: tb/sim_fb_fetch_engine.sv
`timescale 1ns/1ps
module sim_fb_fetch_engine;
    localparam int AW = 16, DW = 32, DEPTH = 64, LVLW = 7, LENW = 5;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst_n, enable;
    logic [AW-1:0]    base0, ceil0, base1, ceil1;
    logic [2:0]       burst_code, thresh_code;
    logic [7:0]       req_delay;
    logic [LVLW-1:0]  fifo_level;
    logic             mem_req, mem_gnt, mem_rvalid;
    logic [AW-1:0]    mem_addr;
    logic [LENW-1:0]  mem_len;
    logic [DW-1:0]    mem_rdata, fifo_wdata;
    logic             fifo_wr, frame_done, frame_buf;

    fb_fetch_engine u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .base0_addr(base0), .ceil0_addr(ceil0), .base1_addr(base1), .ceil1_addr(ceil1),
        .burst_code(burst_code), .thresh_code(thresh_code), .req_delay(req_delay),
        .fifo_level(fifo_level), .mem_req(mem_req), .mem_addr(mem_addr), .mem_len(mem_len),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .frame_done(frame_done), .frame_buf(frame_buf)
    );

    typedef struct packed {
        logic [15:0] b0, c0, b1, c1;
        logic [2:0]  bc;
        logic [7:0]  dly;
        logic        gap;
        logic [15:0] nw;
        logic [7:0]  frames;
    } vec_t;

    // Stimulus table: regions, burst code, delay, beat gaps, words, frames.
    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{16'h0100, 16'h011F, 16'h0200, 16'h021F, 3'd4, 8'd0, 1'b0, 16'd96,  8'd3},
        '{16'h0300, 16'h0309, 16'h0400, 16'h0406, 3'd2, 8'd3, 1'b1, 16'd34,  8'd4},
        '{16'h0500, 16'h0505, 16'h0500, 16'h0505, 3'd3, 8'd1, 1'b0, 16'd30,  8'd5},
        '{16'h0600, 16'h0600, 16'h0700, 16'h0702, 3'd0, 8'd0, 1'b0, 16'd12,  8'd6},
        '{16'h0800, 16'h0827, 16'h0900, 16'h090F, 3'd6, 8'd2, 1'b1, 16'd112, 8'd4}
    };

    int n_tests = 0, n_fail = 0;
    int m_addr, m_region, r_addr, r_region, fd_buf_exp;
    int words_seen, grants, frames_seen;
    bit fd_pend, mon_on, gap_mode, hold_gnt, stray_valid;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int rbase(input int r);
        return (r == 0) ? int'(base0) : int'(base1);
    endfunction
    function automatic int rceil(input int r);
        return (r == 0) ? int'(ceil0) : int'(ceil1);
    endfunction
    // R2: code to words.
    function automatic int blen_of(input int code);
        return (code <= 4) ? (1 << code) : 16;
    endfunction
    // R3: trimmed burst length.
    function automatic int exp_len(input int a, input int r);
        int rem;
        rem = rceil(r) - a + 1;
        return (rem < blen_of(int'(burst_code))) ? rem : blen_of(int'(burst_code));
    endfunction

    task automatic model_init();
        m_addr = rbase(0); m_region = 0;
        r_addr = rbase(0); r_region = 0;
        fd_pend = 0; words_seen = 0; grants = 0; frames_seen = 0;
    endtask

    // Memory responder: grants requests, returns beats carrying their address.
    initial begin : responder
        int pend, paddr, lat_len, lat_addr;
        bit taken, tog;
        pend = 0; paddr = 0; lat_len = 0; lat_addr = 0; taken = 0; tog = 0;
        mem_gnt = 0; mem_rvalid = 0; mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                pend = 0; taken = 0; mem_gnt = 0; mem_rvalid = 0;
            end else begin
                if (taken) begin pend = lat_len; paddr = lat_addr; taken = 0; end
                if (pend > 0 && (!gap_mode || !tog)) begin
                    mem_rvalid = 1; mem_rdata = {16'hC0DE, 16'(paddr)};
                    paddr++; pend--;
                end else begin
                    mem_rvalid = stray_valid; mem_rdata = 32'hDEAD_0000;
                end
                tog = ~tog;
                if (mem_req && !hold_gnt) begin
                    mem_gnt = 1; lat_addr = int'(mem_addr); lat_len = int'(mem_len); taken = 1;
                end else mem_gnt = 0;
            end
        end
    end

    // Monitor: compares requests, writes and frame pulses with the model.
    initial begin : monitor
        forever begin
            @(negedge clk); #1;
            if (rst_n && mon_on) begin
                check(frame_done == fd_pend, "R5", "frame_done", frame_done, fd_pend);
                if (fd_pend && frame_done) begin
                    check(int'(frame_buf) == fd_buf_exp, "R5", "frame_buf", frame_buf, fd_buf_exp);
                    frames_seen++;
                end
                fd_pend = 0;
                if (mem_req && mem_gnt) begin
                    grants++;
                    check(int'(mem_addr) == r_addr, "R4", "mem_addr", mem_addr, r_addr);
                    check(int'(mem_len) == exp_len(r_addr, r_region), "R3", "mem_len",
                          mem_len, exp_len(r_addr, r_region));
                    r_addr += exp_len(r_addr, r_region);
                    if (r_addr > rceil(r_region)) begin r_region ^= 1; r_addr = rbase(r_region); end
                end
                if (fifo_wr) begin
                    words_seen++;
                    check(fifo_wdata == {16'hC0DE, 16'(m_addr)}, "R11", "fifo_wdata",
                          fifo_wdata, {16'hC0DE, 16'(m_addr)});
                    m_addr++;
                    if (m_addr > rceil(m_region)) begin
                        fd_pend = 1; fd_buf_exp = m_region;
                        m_region ^= 1; m_addr = rbase(m_region);
                    end
                end
            end
        end
    end

    task automatic start_run(input int b0, input int c0, input int b1, input int c1,
                             input int bc, input int tc, input int dly);
        @(negedge clk);
        base0 = 16'(b0); ceil0 = 16'(c0); base1 = 16'(b1); ceil1 = 16'(c1);
        burst_code = 3'(bc); thresh_code = 3'(tc); req_delay = 8'(dly);
        model_init();
        enable = 1;
    endtask

    task automatic stop_run();
        @(negedge clk);
        enable = 0;
        repeat (40) @(negedge clk);
        check(mem_req == 0, "R12", "mem_req after stop", mem_req, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        bit seen;
        int k, g0, a0, l0;
        rst_n = 0; enable = 0; mon_on = 0; gap_mode = 0; hold_gnt = 0; stray_valid = 0;
        base0 = '0; ceil0 = '0; base1 = '0; ceil1 = '0;
        burst_code = 3'd4; thresh_code = 3'd7; req_delay = '0; fifo_level = '0;
        repeat (5) @(negedge clk);
        // R1: during reset
        check(mem_req == 0 && fifo_wr == 0 && frame_done == 0, "R1", "outputs in reset",
              {mem_req, fifo_wr, frame_done}, 0);
        rst_n = 1;
        @(negedge clk); #2;
        // R1: after release
        check(mem_req == 0 && fifo_wr == 0 && frame_done == 0, "R1", "outputs after reset",
              {mem_req, fifo_wr, frame_done}, 0);
        mon_on = 1;

        // Table walk: R2 R3 R4 R5 R6 R11
        for (int i = 0; i < NV; i++) begin
            int t;
            gap_mode = VECS[i].gap;
            start_run(VECS[i].b0, VECS[i].c0, VECS[i].b1, VECS[i].c1, VECS[i].bc, 7, VECS[i].dly);
            t = 0;
            while (words_seen < int'(VECS[i].nw) && t < 5000) begin @(negedge clk); t++; end
            check(words_seen >= int'(VECS[i].nw), "R3", "words fetched", words_seen, VECS[i].nw);
            stop_run();
            // R4 R6: frame count over the run
            check(frames_seen == int'(VECS[i].frames), (VECS[i].b0 == VECS[i].b1) ? "R6" : "R4",
                  "frames", frames_seen, VECS[i].frames);
        end
        gap_mode = 0;

        // R9: request latency from enable, delays 0 and 5
        foreach (VECS[j]) begin
            int d;
            if (j > 1) continue;
            d = (j == 0) ? 0 : 5;
            start_run(16'h0A00, 16'h0A3F, 16'h0B00, 16'h0B3F, 4, 7, d);
            k = 0;
            for (int n = 0; n < 50; n++) begin
                @(posedge clk); k++;
                @(negedge clk); #2;
                if (mem_req) break;
            end
            check(k == d + 3, "R9", "edges to first request", k, d + 3);
            stop_run();
        end

        // R7: threshold code 1 gives 16 words
        fifo_level = 7'd16;
        start_run(16'h0A00, 16'h0A3F, 16'h0B00, 16'h0B3F, 4, 1, 0);
        seen = 0;
        repeat (40) begin @(negedge clk); #2; seen |= mem_req; end
        check(!seen, "R7", "request at level 16", seen, 0);
        fifo_level = 7'd15;
        repeat (10) begin @(negedge clk); #2; seen |= mem_req; end
        check(seen, "R7", "request at level 15", seen, 1);
        stop_run();

        // R8: free space must hold the 16-word burst
        fifo_level = 7'd50;
        start_run(16'h0A00, 16'h0A3F, 16'h0B00, 16'h0B3F, 4, 7, 0);
        seen = 0;
        repeat (40) begin @(negedge clk); #2; seen |= mem_req; end
        check(!seen, "R8", "request with 14 free", seen, 0);
        fifo_level = 7'd48;
        repeat (10) begin @(negedge clk); #2; seen |= mem_req; end
        check(seen, "R8", "request with 16 free", seen, 1);
        stop_run();
        fifo_level = '0;

        // R10: request held without grant
        hold_gnt = 1;
        start_run(16'h0C00, 16'h0C3F, 16'h0D00, 16'h0D3F, 4, 7, 0);
        for (int n = 0; n < 20 && !mem_req; n++) begin @(negedge clk); #2; end
        a0 = int'(mem_addr); l0 = int'(mem_len);
        repeat (5) @(negedge clk);
        #2;
        check(mem_req == 1, "R10", "mem_req held", mem_req, 1);
        check(int'(mem_addr) == a0 && int'(mem_len) == l0, "R10", "addr held", mem_addr, a0);
        hold_gnt = 0;
        stop_run();

        // R12: disable during a burst, then restart at region 0
        start_run(16'h0C00, 16'h0C3F, 16'h0D00, 16'h0D3F, 4, 7, 0);
        for (int n = 0; n < 30 && !fifo_wr; n++) begin @(negedge clk); #2; end
        enable = 0;
        g0 = grants;
        repeat (40) @(negedge clk);
        check(grants == g0, "R12", "grants after disable", grants, g0);
        check(words_seen == 16, "R12", "words of last burst", words_seen, 16);
        model_init();
        enable = 1;
        for (int n = 0; n < 20 && !mem_req; n++) begin @(negedge clk); #2; end
        check(int'(mem_addr) == 16'h0C00, "R12", "restart address", mem_addr, 16'h0C00);
        stop_run();

        // R11: stray beats while idle
        stray_valid = 1;
        seen = 0;
        repeat (5) begin @(negedge clk); #2; seen |= fifo_wr; end
        check(!seen, "R11", "write from stray beat", seen, 0);
        stray_valid = 0;
        @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule